// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

This block chooses which hardware thread the commit stage of a multithreaded core retires from next. Each thread reports a status code, whether its reorder-buffer partition is empty, whether its oldest entry is ready to retire, and that entry's sequence number. A static policy input picks one of three arbitration schemes. The block returns a valid flag and the index of the chosen thread. The choice is combinational, so a retire loop can ask for a pick several times in one cycle.

The round-robin scheme keeps a priority list of thread indices. When the retire loop accepts a round-robin pick, the winner moves to the back of that list. The age-based schemes compare the head sequence numbers of the qualifying threads and favour the oldest. A build with a single thread reduces to a plain status test.

Top module: `csel_commit_pick`

## Requirements
- R1: A thread is eligible only when its 3-bit status is idle (0), running (1) or fetch-trap-pending (4). Squashing (2) and trap-pending (3) are never eligible.
- R2: With more than one thread, a thread is a candidate only when it is eligible, its empty flag is 0 and its head-ready flag is 1.
- R3: Under the age policy (policy 2'b10), the pick is the candidate with the smallest head sequence number.
- R4: Under an age-based policy, equal smallest sequence numbers resolve to the lower thread index.
- R5: Policy codes 2'b00 (greedy) and 2'b11 select exactly as the age policy does.
- R6: Under the rotate policy (policy 2'b01), the pick is the first candidate found when the priority list is scanned from its front.
- R7: After reset the priority list holds the thread indices in ascending order, with thread 0 at the front.
- R8: When take_i is 1 during a valid rotate-policy pick, the winner moves to the tail of the list from the next clock edge onward. The other threads keep their relative order.
- R9: The priority list stays unchanged when take_i is 0, when the policy is not rotate, or when no pick is valid.
- R10: When no thread qualifies, pick_vld_o is 0 and pick_tid_o is 0.
- R11: With a single thread, pick_vld_o equals that thread's eligibility, and the empty and head-ready flags have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Arbitration policy code |
| status_i | input | 3*NT | Per-thread status codes, thread i at bits [3i+2:3i] |
| empty_i | input | NT | Per-thread buffer-empty flags |
| head_rdy_i | input | NT | Per-thread head-ready flags |
| head_seq_i | input | SW*NT | Per-thread head sequence numbers |
| take_i | input | 1 | Retire loop accepted the current pick |
| pick_vld_o | output | 1 | A thread was chosen |
| pick_tid_o | output | TW | Index of the chosen thread |

## Verification
The hardest condition to reach is a rotate-policy pick from a priority list that has been rotated several times into a non-ascending order. In that state the front of the list is not the lowest candidate index. To get there, the stimulus runs a chain of accepted picks with all threads ready. It then narrows the candidate set so that only the list order decides the winner. Between those steps it interleaves rejected picks and picks under other policies, to show that the list holds still. A second, single-thread instance covers the reduced build.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic [2:0] {
    TS_IDLE   = 3'd0,
    TS_RUN    = 3'd1,
    TS_SQUASH = 3'd2,
    TS_TRAP   = 3'd3,
    TS_FTRAP  = 3'd4
  } tstat_e;

  typedef enum logic [1:0] {
    POL_GREEDY  = 2'd0,
    POL_ROTATE  = 2'd1,
    POL_AGE     = 2'd2,
    POL_AGE_ALT = 2'd3
  } pol_e;

  function automatic logic stat_ok(input logic [2:0] s);
    return (s == TS_IDLE) || (s == TS_RUN) || (s == TS_FTRAP);
  endfunction
endpackage

// File: rtl/csel_qualify.sv
module csel_qualify #(
  parameter int NT = 4
) (
  input  logic [3*NT-1:0] status_i,
  input  logic [NT-1:0]   empty_i,
  input  logic [NT-1:0]   head_rdy_i,
  output logic [NT-1:0]   elig_o,
  output logic [NT-1:0]   cand_o
);
  import csel_pkg::*;

  for (genvar i = 0; i < NT; i++) begin : g_thr
    assign elig_o[i] = stat_ok(status_i[3*i +: 3]);
    assign cand_o[i] = elig_o[i] & ~empty_i[i] & head_rdy_i[i];
  end
endmodule

// File: rtl/csel_oldest.sv
module csel_oldest #(
  parameter int NT = 4,
  parameter int SW = 16,
  parameter int TW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NT-1:0]  cand_i,
  input  logic [SW*NT-1:0] seq_i,
  output logic           vld_o,
  output logic [TW-1:0]  tid_o
);
  logic [SW-1:0] best_seq;

  always_comb begin
    vld_o    = 1'b0;
    tid_o    = '0;
    best_seq = '0;
    for (int i = 0; i < NT; i++) begin
      if (cand_i[i] && (!vld_o || (seq_i[SW*i +: SW] < best_seq))) begin
        vld_o    = 1'b1;
        tid_o    = TW'(i);
        best_seq = seq_i[SW*i +: SW];
      end
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_chk
    assert_oldest_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && cand_i[i]) |-> (seq_i[SW*tid_o +: SW] <= seq_i[SW*i +: SW]));
    assert_tie_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && cand_i[i] && (seq_i[SW*tid_o +: SW] == seq_i[SW*i +: SW]))
        |-> (tid_o <= TW'(i)));
  end
endmodule

// File: rtl/csel_rrlist.sv
module csel_rrlist #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] cand_i,
  input  logic          rot_en_i,
  output logic          vld_o,
  output logic [TW-1:0] tid_o
);
  logic [NT-1:0][TW-1:0] order_q, order_d;
  logic [TW-1:0] pos;
  logic          upd;

  always_comb begin
    vld_o = 1'b0;
    pos   = '0;
    for (int k = 0; k < NT; k++) begin
      if (!vld_o && cand_i[order_q[k]]) begin
        vld_o = 1'b1;
        pos   = TW'(k);
      end
    end
    tid_o = order_q[pos];
  end

  assign upd = rot_en_i & vld_o;

  always_comb begin
    for (int j = 0; j < NT; j++) begin
      if (TW'(j) < pos)   order_d[j] = order_q[j];
      else if (j < NT-1)  order_d[j] = order_q[j+1];
      else                order_d[j] = tid_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NT; j++) order_q[j] <= TW'(j);
    end else if (upd) begin
      order_q <= order_d;
    end
  end

  assert_tail_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (order_q[NT-1] == $past(tid_o)));
  assert_list_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(order_q));
  assert_front_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && cand_i[order_q[0]]) |-> (tid_o == order_q[0]));
endmodule

// File: rtl/csel_commit_pick.sv
module csel_commit_pick #(
  parameter int NT = 4,
  parameter int SW = 16,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy_i,
  input  logic [3*NT-1:0]  status_i,
  input  logic [NT-1:0]    empty_i,
  input  logic [NT-1:0]    head_rdy_i,
  input  logic [SW*NT-1:0] head_seq_i,
  input  logic             take_i,
  output logic             pick_vld_o,
  output logic [TW-1:0]    pick_tid_o
);
  import csel_pkg::*;

  logic [NT-1:0] elig, cand;

  csel_qualify #(.NT(NT)) u_qual (
    .status_i  (status_i),
    .empty_i   (empty_i),
    .head_rdy_i(head_rdy_i),
    .elig_o    (elig),
    .cand_o    (cand)
  );

  if (NT == 1) begin : g_single
    logic unused;
    assign unused     = cand[0] ^ take_i ^ (^policy_i) ^ (^head_seq_i);
    assign pick_vld_o = elig[0];
    assign pick_tid_o = '0;
  end else begin : g_multi
    logic          rr_sel, rr_vld, age_vld;
    logic [TW-1:0] rr_tid, age_tid;

    assign rr_sel = (policy_i == POL_ROTATE);

    csel_oldest #(.NT(NT), .SW(SW), .TW(TW)) u_age (
      .clk   (clk),
      .rst_n (rst_n),
      .cand_i(cand),
      .seq_i (head_seq_i),
      .vld_o (age_vld),
      .tid_o (age_tid)
    );

    csel_rrlist #(.NT(NT), .TW(TW)) u_rr (
      .clk     (clk),
      .rst_n   (rst_n),
      .cand_i  (cand),
      .rot_en_i(take_i & rr_sel),
      .vld_o   (rr_vld),
      .tid_o   (rr_tid)
    );

    always_comb begin
      pick_vld_o = rr_sel ? rr_vld : age_vld;
      pick_tid_o = pick_vld_o ? (rr_sel ? rr_tid : age_tid) : '0;
    end

    assert_pick_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pick_vld_o |-> cand[pick_tid_o]);
    assert_none_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cand == '0) |-> (!pick_vld_o && pick_tid_o == '0));
  end
endmodule

// File: tb/sim_csel_commit_pick.sv
module sim_csel_commit_pick;
  localparam int NT = 4;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]       pol;
  logic [3*NT-1:0]  st;
  logic [NT-1:0]    emp, rdy;
  logic [SW*NT-1:0] seq;
  logic             take;
  logic             vld;
  logic [1:0]       tid;
  logic [2:0]       st1;
  logic             emp1, rdy1, vld1;
  logic [0:0]       tid1;

  csel_commit_pick #(.NT(NT), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .policy_i(pol), .status_i(st), .empty_i(emp),
    .head_rdy_i(rdy), .head_seq_i(seq), .take_i(take),
    .pick_vld_o(vld), .pick_tid_o(tid));

  csel_commit_pick #(.NT(1), .SW(SW)) u1 (
    .clk(clk), .rst_n(rst_n), .policy_i(pol), .status_i(st1), .empty_i(emp1),
    .head_rdy_i(rdy1), .head_seq_i(seq[SW-1:0]), .take_i(take),
    .pick_vld_o(vld1), .pick_tid_o(tid1));

  typedef struct {
    logic  v;
    int    t;
    logic  v1;
    string tag;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   errors = 0;
  int   checks = 0;
  bit   done   = 0;
  int   lst[NT];

  function automatic bit ok_m(input logic [2:0] s);
    return s == 3'd0 || s == 3'd1 || s == 3'd4;
  endfunction

  task automatic step(input string tag, input logic [1:0] p, input logic [11:0] s,
                      input logic [3:0] e, input logic [3:0] r, input logic [31:0] sq,
                      input logic tk, input logic [2:0] s1, input logic e1, input logic r1);
    exp_t x;
    bit   c[NT];
    int   pos;
    @(negedge clk);
    pol = p; st = s; emp = e; rdy = r; seq = sq; take = tk;
    st1 = s1; emp1 = e1; rdy1 = r1;
    for (int i = 0; i < NT; i++) c[i] = ok_m(s[3*i +: 3]) && !e[i] && r[i];
    x.v = 0; x.t = 0; pos = 0;
    if (p == 2'b01) begin
      for (int k = 0; k < NT; k++)
        if (!x.v && c[lst[k]]) begin x.v = 1; x.t = lst[k]; pos = k; end
    end else begin
      for (int i = 0; i < NT; i++)
        if (c[i] && (!x.v || sq[SW*i +: SW] < sq[SW*x.t +: SW])) begin x.v = 1; x.t = i; end
    end
    x.v1 = ok_m(s1);
    x.tag = tag;
    #1;
    q.push_back(x);
    -> chk_ev;
    @(posedge clk);
    if (tk && p == 2'b01 && x.v) begin
      for (int k = pos; k < NT-1; k++) lst[k] = lst[k+1];
      lst[NT-1] = x.t;
    end
  endtask

  initial begin
    forever begin
      exp_t x;
      @(chk_ev);
      x = q.pop_front();
      checks++;
      if (vld !== x.v || int'(tid) != x.t) begin
        errors++;
        $display("FAIL %s: got vld=%0b tid=%0d expected vld=%0b tid=%0d", x.tag, vld, tid, x.v, x.t);
      end
      checks++;
      if (vld1 !== x.v1) begin
        errors++;
        $display("FAIL %s (single): got vld=%0b expected vld=%0b", x.tag, vld1, x.v1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [11:0] ALLRUN = {3'd1, 3'd1, 3'd1, 3'd1};

  initial begin
    for (int k = 0; k < NT; k++) lst[k] = k;
    pol = 0; st = '0; emp = '0; rdy = '0; seq = '0; take = 0;
    st1 = 0; emp1 = 0; rdy1 = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R7 reset order, R6 first in list, R11 single thread ignores flags
    step("R7 reset list front", 2'b01, ALLRUN, 4'h0, 4'hF, 32'h0, 0, 3'd1, 1, 0);
    step("R9 no take keeps list", 2'b01, ALLRUN, 4'h0, 4'hF, 32'h0, 0, 3'd0, 0, 1);
    // R8 rotations
    step("R8 take t0", 2'b01, ALLRUN, 4'h0, 4'hF, 32'h0, 1, 3'd4, 1, 1);
    step("R8 t0 moved to tail", 2'b01, ALLRUN, 4'h0, 4'hF, 32'h0, 1, 3'd2, 0, 1);
    step("R8 t1 moved, list 2301", 2'b01, ALLRUN, 4'h0, 4'h3, 32'h0, 1, 3'd3, 0, 1);
    step("R6 list order 2310 picks t1", 2'b01, ALLRUN, 4'h0, 4'h3, 32'h0, 0, 3'd1, 0, 0);
    // R9 policy other than rotate with take does not rotate
    step("R9 age take no rotate", 2'b10, ALLRUN, 4'h0, 4'hF, 32'h10203040, 1, 3'd1, 0, 0);
    step("R9 list unchanged", 2'b01, ALLRUN, 4'h0, 4'h3, 32'h0, 0, 3'd1, 0, 0);
    // R9 invalid pick with take
    step("R10 rotate none valid", 2'b01, ALLRUN, 4'h0, 4'h0, 32'h0, 1, 3'd1, 0, 0);
    step("R9 list unchanged after invalid", 2'b01, ALLRUN, 4'h0, 4'hF, 32'h0, 0, 3'd1, 0, 0);
    step("R6 full list front t2", 2'b01, ALLRUN, 4'h0, 4'hF, 32'h0, 1, 3'd1, 0, 0);
    step("R6 front t3 after rotate", 2'b01, ALLRUN, 4'h0, 4'hF, 32'h0, 0, 3'd1, 0, 0);
    // R1 statuses
    step("R1 squash and trap excluded", 2'b01, {3'd1, 3'd3, 3'd2, 3'd2}, 4'h0, 4'hF, 32'h0, 0, 3'd2, 0, 1);
    step("R1 idle and ftrap eligible", 2'b10, {3'd2, 3'd0, 3'd4, 3'd3}, 4'h0, 4'hF, 32'h01020305, 0, 3'd4, 0, 0);
    // R2 empty / ready
    step("R2 empty thread skipped", 2'b10, ALLRUN, 4'h1, 4'hF, 32'h09080706, 0, 3'd1, 0, 0);
    step("R2 unready thread skipped", 2'b10, ALLRUN, 4'h0, 4'h7, 32'h01050607, 0, 3'd1, 0, 0);
    // R3 age
    step("R3 oldest t2", 2'b10, ALLRUN, 4'h0, 4'hF, 32'h40105080, 0, 3'd1, 0, 0);
    step("R3 oldest t3", 2'b10, ALLRUN, 4'h0, 4'hF, 32'h03FFFFFF, 0, 3'd1, 0, 0);
    // R4 ties
    step("R4 tie low index", 2'b10, ALLRUN, 4'h0, 4'hF, 32'h20101090, 0, 3'd1, 0, 0);
    step("R4 all equal t0", 2'b00, ALLRUN, 4'h0, 4'hF, 32'h55555555, 0, 3'd1, 0, 0);
    // R5 greedy and alt
    step("R5 greedy as age", 2'b00, ALLRUN, 4'h0, 4'hF, 32'h30602010, 0, 3'd1, 0, 0);
    step("R5 code 3 as age", 2'b11, ALLRUN, 4'h0, 4'hE, 32'h30600710, 1, 3'd1, 0, 0);
    // R10 none
    step("R10 age none valid", 2'b10, {3'd2, 3'd2, 3'd3, 3'd3}, 4'h0, 4'hF, 32'h0, 0, 3'd3, 1, 1);
    step("R6 list after non-rotate take", 2'b01, ALLRUN, 4'h0, 4'hF, 32'h0, 0, 3'd0, 1, 1);
    @(negedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule